// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow word

This block is the execute stage of a small 16-bit processor. A sequencer hands it one basic operation at a time: a 4-bit opcode and two 16-bit operand values. The block produces the destination value, a destination write enable and a condition flag for the four compare opcodes. It keeps the processor's 16-bit overflow word, updates it as each opcode requires, and drives it out for reading at all times.

Operations enter through a valid/ready input and leave through a valid/ready output. Only one operation is in flight at a time. The input is ready only while the block is idle, so the sequencer stalls by holding its request. Each opcode occupies a fixed number of extra execute cycles (zero, one or two), which are reported with the result so the sequencer can account for them. The result stays on the output, unchanged, until the consumer takes it. The overflow word is written at the moment of that hand-off. Back-pressure therefore never exposes a half-updated overflow word.

Top module: `ovf_alu16`

## Requirements
- R1: `in_ready` is high only while no operation is in flight. An operation is accepted on a rising edge with `in_valid` and `in_ready` both high, and `in_valid` is ignored at all other times. `out_valid` and every `out_*` value stay constant until an edge with `out_ready` high. `in_ready` returns high in the cycle after that hand-off.
- R2: `out_valid` rises E+1 clock edges after the accepting edge, where E is the opcode's extra cycle count, and `out_cycles` shows E. E is 0 for codes 0x0, 0x1, 0x9, 0xA and 0xB. E is 1 for codes 0x2, 0x3, 0x4, 0x7, 0x8 and 0xC–0xF. E is 2 for codes 0x5 and 0x6.
- R3: Code 0x1 (copy) writes b. Codes 0x9, 0xA and 0xB write a AND b, a OR b and a XOR b. All four assert `out_wr` and leave the overflow word unchanged.
- R4: Code 0x2 writes (a+b) mod 2^16 and sets the overflow word to 0x0001 on carry out, otherwise to 0x0000. Code 0x3 writes (a−b) mod 2^16 and sets it to 0xFFFF when b > a, otherwise to 0x0000.
- R5: Code 0x4 writes the low half of the 32-bit product a*b and puts the high half in the overflow word.
- R6: Code 0x5 writes floor(a/b) and sets the overflow word to the low 16 bits of floor(a·2^16/b); with b = 0 both become 0. Code 0x6 writes a mod b, writes 0 when b = 0, and never changes the overflow word.
- R7: Code 0x7 writes the low 16 bits of a·2^b and sets the overflow word to bits 31:16 of that 32-bit value. Code 0x8 writes a>>b and sets the overflow word to bits 15:0 of (a·2^16)>>b. Any b of 16 or more gives a written value of 0, and any b of 32 or more also gives an overflow word of 0.
- R8: Codes 0xC, 0xD, 0xE and 0xF set `out_cond` to a==b, a!=b, a>b (unsigned) and (a AND b)!=0 respectively. They drive `out_wr` low and `out_result` to 0, and leave the overflow word unchanged.
- R9: Code 0x0 (non-basic) drives `out_wr` low, `out_cond` low and `out_result` to 0, and leaves the overflow word unchanged.
- R10: After reset the overflow word is 0x0000, `in_ready` is high and `out_valid` is low. The overflow word changes only on the hand-off edge of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Block idle, request will be taken |
| in_op | input | 4 | Basic opcode |
| in_a | input | 16 | First operand (destination value) |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Value for the destination |
| out_wr | output | 1 | Destination is written |
| out_cond | output | 1 | Compare outcome |
| out_cycles | output | 2 | Extra execute cycles of this opcode |
| ovf_word | output | 16 | Current overflow word |

## Verification
The hardest situation to reach is the interplay of back-pressure with the overflow word. The word must keep its old value through a held result and change only at the hand-off. Opcodes that do not define the word must carry forward whatever the previous opcode left. The vector table is therefore walked in order, with expected overflow values chained from row to row. Rows that keep the word follow rows that set it to distinctive values such as 0x8000 and 0xFFFE. A directed test then holds a divide result for several cycles and pushes a second request at the busy input, so that both the stability of the held result and the discarding of the second request are observed at the ports.

// File: rtl/ovf_alu16_pkg.sv
package ovf_alu16_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned EXT_W  = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_EXT  = 4'h0,
    OPC_MOV  = 4'h1,
    OPC_ADD  = 4'h2,
    OPC_SUB  = 4'h3,
    OPC_MUL  = 4'h4,
    OPC_DIV  = 4'h5,
    OPC_MOD  = 4'h6,
    OPC_SHL  = 4'h7,
    OPC_SHR  = 4'h8,
    OPC_AND  = 4'h9,
    OPC_OR   = 4'hA,
    OPC_XOR  = 4'hB,
    OPC_TEQ  = 4'hC,
    OPC_TNE  = 4'hD,
    OPC_TGT  = 4'hE,
    OPC_TBIT = 4'hF
  } opc_e;

  // Extra execute cycles beyond the decode cycle
  function automatic logic [EXT_W-1:0] extra_cycles(opc_e op);
    case (op)
      OPC_DIV, OPC_MOD:                    return 2'd2;
      OPC_ADD, OPC_SUB, OPC_MUL, OPC_SHL,
      OPC_SHR, OPC_TEQ, OPC_TNE, OPC_TGT,
      OPC_TBIT:                            return 2'd1;
      default:                             return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ovf_alu16_datapath.sv
module ovf_alu16_datapath
  import ovf_alu16_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  opc_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] ovf_cur,
  output logic [W-1:0] res,
  output logic         wr,
  output logic         cond,
  output logic [W-1:0] ovf_nxt
);

  localparam int unsigned DW   = 2 * W;
  localparam int unsigned SH_W = $clog2(DW);

  logic [W:0]    sum_w, dif_w;
  logic [DW-1:0] prod_w, quo_w, shl_w, shr_w;
  logic [W-1:0]  div_safe, rem_w;
  logic          div_zero, sh_big;
  logic [SH_W-1:0] sh_amt;

  assign div_zero = (b == '0);
  assign div_safe = div_zero ? {{(W-1){1'b0}}, 1'b1} : b;
  assign sum_w    = {1'b0, a} + {1'b0, b};
  assign dif_w    = {1'b0, a} - {1'b0, b};
  assign prod_w   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  // One wide quotient serves both the integer part and the fractional word
  assign quo_w    = {a, {W{1'b0}}} / {{W{1'b0}}, div_safe};
  assign rem_w    = a % div_safe;
  assign sh_big   = |b[W-1:SH_W];
  assign sh_amt   = b[SH_W-1:0];
  assign shl_w    = sh_big ? '0 : ({{W{1'b0}}, a} << sh_amt);
  assign shr_w    = sh_big ? '0 : ({a, {W{1'b0}}} >> sh_amt);

  always_comb begin
    res     = '0;
    wr      = 1'b0;
    cond    = 1'b0;
    ovf_nxt = ovf_cur;
    case (op)
      OPC_MOV: begin res = b;     wr = 1'b1; end
      OPC_AND: begin res = a & b; wr = 1'b1; end
      OPC_OR:  begin res = a | b; wr = 1'b1; end
      OPC_XOR: begin res = a ^ b; wr = 1'b1; end
      OPC_ADD: begin
        res     = sum_w[W-1:0];
        wr      = 1'b1;
        ovf_nxt = {{(W-1){1'b0}}, sum_w[W]};
      end
      OPC_SUB: begin
        res     = dif_w[W-1:0];
        wr      = 1'b1;
        ovf_nxt = {W{dif_w[W]}};
      end
      OPC_MUL: begin
        res     = prod_w[W-1:0];
        wr      = 1'b1;
        ovf_nxt = prod_w[DW-1:W];
      end
      OPC_DIV: begin
        res     = div_zero ? '0 : quo_w[DW-1:W];
        wr      = 1'b1;
        ovf_nxt = div_zero ? '0 : quo_w[W-1:0];
      end
      OPC_MOD: begin
        res = div_zero ? '0 : rem_w;
        wr  = 1'b1;
      end
      OPC_SHL: begin
        res     = shl_w[W-1:0];
        wr      = 1'b1;
        ovf_nxt = shl_w[DW-1:W];
      end
      OPC_SHR: begin
        res     = shr_w[DW-1:W];
        wr      = 1'b1;
        ovf_nxt = shr_w[W-1:0];
      end
      OPC_TEQ:  cond = (a == b);
      OPC_TNE:  cond = (a != b);
      OPC_TGT:  cond = (a > b);
      OPC_TBIT: cond = ((a & b) != '0);
      default: ;
    endcase
  end

  // R6: zero divisor never produces a nonzero destination value
  always_comb begin
    if (((op == OPC_DIV) || (op == OPC_MOD)) && div_zero)
      AST_DIV_ZERO: assert (res == '0); // R6
  end

  // R8: compares never write the destination
  always_comb begin
    if ((op == OPC_TEQ) || (op == OPC_TNE) || (op == OPC_TGT) || (op == OPC_TBIT))
      AST_TEST_NO_WRITE: assert (!wr && res == '0); // R8
  end

endmodule

// File: rtl/ovf_alu16_ctrl.sv
module ovf_alu16_ctrl
  import ovf_alu16_pkg::*;
#(
  parameter int unsigned CNT_W = EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [CNT_W-1:0] extra,
  output logic             accept,
  output logic             handoff,
  output logic             in_ready,
  output logic             out_valid
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign handoff   = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          if (extra == '0) st_q <= ST_DONE;
          else begin
            st_q  <= ST_WAIT;
            cnt_q <= extra - 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) st_q <= ST_DONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Checker state: edges since acceptance and the promised extra count
  logic [CNT_W:0]   age_q;
  logic [CNT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      lat_q <= '0;
    end else if (accept) begin
      age_q <= 1;
      lat_q <= extra;
    end else if (!out_valid) begin
      age_q <= age_q + 1'b1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (age_q == {1'b0, lat_q} + 1'b1)); // R2

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R1

  AST_READY_AFTER_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> (in_ready && !out_valid)); // R1

endmodule

// File: rtl/ovf_alu16.sv
module ovf_alu16
  import ovf_alu16_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_wr,
  output logic         out_cond,
  output logic [1:0]   out_cycles,
  output logic [W-1:0] ovf_word
);

  opc_e         op_q;
  logic [W-1:0] a_q, b_q, ovf_q, ovf_nxt;
  logic         accept, handoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OPC_EXT;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= opc_e'(in_op);
      a_q  <= in_a;
      b_q  <= in_b;
    end
  end

  ovf_alu16_ctrl #(.CNT_W(EXT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .extra     (extra_cycles(opc_e'(in_op))),
    .accept    (accept),
    .handoff   (handoff),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  ovf_alu16_datapath #(.W(W)) dp_i (
    .op      (op_q),
    .a       (a_q),
    .b       (b_q),
    .ovf_cur (ovf_q),
    .res     (out_result),
    .wr      (out_wr),
    .cond    (out_cond),
    .ovf_nxt (ovf_nxt)
  );

  assign out_cycles = extra_cycles(op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= '0;
    else if (handoff) ovf_q <= ovf_nxt;
  end

  assign ovf_word = ovf_q;

  AST_OVF_AT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !handoff |=> $stable(ovf_word)); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_result) && $stable(out_wr)
                                   && $stable(out_cond) && $stable(out_cycles))); // R1

  AST_MOD_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff && op_q == OPC_MOD) |=> $stable(ovf_word)); // R6

endmodule

// File: tb/ovf_alu16_tb_top.sv
module ovf_alu16_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_result;
  logic        out_wr, out_cond;
  logic [1:0]  out_cycles;
  logic [15:0] ovf_word;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ovf_alu16 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr(out_wr),
    .out_cond(out_cond), .out_cycles(out_cycles), .ovf_word(ovf_word)
  );

  // {op, a, b, result, wr, cond, overflow after hand-off, extra cycles}
  localparam int NV = 27;
  localparam logic [71:0] VEC [NV] = '{
    {4'h1, 16'h1234, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0, 16'h0000, 2'd0},
    {4'h2, 16'hFFFF, 16'h0002, 16'h0001, 1'b1, 1'b0, 16'h0001, 2'd1},
    {4'h9, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b1, 1'b0, 16'h0001, 2'd0},
    {4'h2, 16'h1000, 16'h2000, 16'h3000, 1'b1, 1'b0, 16'h0000, 2'd1},
    {4'h3, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 1'b0, 16'hFFFF, 2'd1},
    {4'hA, 16'h1200, 16'h0034, 16'h1234, 1'b1, 1'b0, 16'hFFFF, 2'd0},
    {4'h3, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0, 16'h0000, 2'd1},
    {4'h4, 16'h1234, 16'h0100, 16'h3400, 1'b1, 1'b0, 16'h0012, 2'd1},
    {4'hB, 16'hFFFF, 16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 16'h0012, 2'd0},
    {4'h5, 16'h0007, 16'h0002, 16'h0003, 1'b1, 1'b0, 16'h8000, 2'd2},
    {4'h6, 16'h0007, 16'h0003, 16'h0001, 1'b1, 1'b0, 16'h8000, 2'd2},
    {4'h6, 16'h1234, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h8000, 2'd2},
    {4'h5, 16'h1234, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000, 2'd2},
    {4'h7, 16'h8001, 16'h0001, 16'h0002, 1'b1, 1'b0, 16'h0001, 2'd1},
    {4'h8, 16'h8001, 16'h0004, 16'h0800, 1'b1, 1'b0, 16'h1000, 2'd1},
    {4'h7, 16'h00FF, 16'h0010, 16'h0000, 1'b1, 1'b0, 16'h00FF, 2'd1},
    {4'h8, 16'h1234, 16'h0014, 16'h0000, 1'b1, 1'b0, 16'h0123, 2'd1},
    {4'h7, 16'h1234, 16'h0028, 16'h0000, 1'b1, 1'b0, 16'h0000, 2'd1},
    {4'h4, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 16'hFFFE, 2'd1},
    {4'hC, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b1, 16'hFFFE, 2'd1},
    {4'hC, 16'h0005, 16'h0006, 16'h0000, 1'b0, 1'b0, 16'hFFFE, 2'd1},
    {4'hD, 16'h0005, 16'h0006, 16'h0000, 1'b0, 1'b1, 16'hFFFE, 2'd1},
    {4'hE, 16'h8000, 16'h7FFF, 16'h0000, 1'b0, 1'b1, 16'hFFFE, 2'd1},
    {4'hE, 16'h7FFF, 16'h8000, 16'h0000, 1'b0, 1'b0, 16'hFFFE, 2'd1},
    {4'hF, 16'h0F00, 16'h0100, 16'h0000, 1'b0, 1'b1, 16'hFFFE, 2'd1},
    {4'hF, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b0, 1'b0, 16'hFFFE, 2'd1},
    {4'h0, 16'h0001, 16'h0002, 16'h0000, 1'b0, 1'b0, 16'hFFFE, 2'd0}
  };

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h0:                      return "R9";
      4'h1, 4'h9, 4'hA, 4'hB:    return "R3";
      4'h2, 4'h3:                return "R4";
      4'h4:                      return "R5";
      4'h5, 4'h6:                return "R6";
      4'h7, 4'h8:                return "R7";
      default:                   return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issue one operation at a negedge; returns edges until out_valid
  task automatic issue(logic [3:0] op, logic [15:0] a, logic [15:0] b, output int n);
    in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (!out_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10", "reset ovf", ovf_word, 0);
    check("R10", "reset in_ready", in_ready, 1);
    check("R10", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, overflow word chained from row to row
    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[71:68]);
      issue(v[71:68], v[67:52], v[51:36], n);
      check("R2", "latency", n, v[1:0] + 1);
      check("R2", "out_cycles", out_cycles, v[1:0]);
      check(t, "result", out_result, v[35:20]);
      check(t, "wr", out_wr, v[19]);
      check(t, "cond", out_cond, v[18]);
      check("R1", "in_ready while valid", in_ready, 0);
      take();
      check(t, "ovf after hand-off", ovf_word, v[17:2]);
      check("R1", "ready after hand-off", in_ready, 1);
    end

    // R1/R10: back-pressure on a divide, extra request while busy
    in_op = 4'h5; in_a = 16'h0064; in_b = 16'h0007; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_op = 4'h1; in_a = 16'h5555; in_b = 16'hAAAA; // held request while busy
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "divide valid", out_valid, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "held valid", out_valid, 1);
      check("R1", "held result", out_result, 16'h000E);
      check("R10", "ovf not yet updated", ovf_word, 16'hFFFE);
    end
    take();
    check("R6", "divide ovf", ovf_word, 16'h4924);
    @(negedge clk);
    check("R1", "busy request dropped", out_valid, 0);
    check("R1", "idle after drop", in_ready, 1);

    // R10: reset in the middle of an operation
    issue(4'h4, 16'hFFFF, 16'h0003, n);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "mid-op reset ovf", ovf_word, 0);
    check("R10", "mid-op reset valid", out_valid, 0);
    check("R10", "mid-op reset ready", in_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule